// File: doc/BRIEF.md
# Interrupt Vector Ring Writer

This block collects interrupt events raised by on-chip sources and turns each one into a 16-byte vector that it stores in a circular buffer in memory. Each event carries a source identifier, source data, a ring identifier, a virtual-memory identifier and a process address-space identifier. Events enter through a valid/ready port and wait in a small FIFO. A write engine then moves each vector to memory as four 32-bit beats on a valid/ready write-request port.

Software places the ring anywhere on a 256-byte boundary in a 40-bit address space and chooses its size as a power of two. It reads the write pointer, consumes vectors, and returns the read pointer. While unread vectors remain, the block holds its interrupt line high. It can also detect when the ring overruns and flag it. Optionally, after every vector it stores a copy of the write pointer at a second memory address, so software can poll memory instead of the register.

Top module: `ivr_ring_writer`

## Requirements
- R1: Each vector is sent as four beats in order, at byte addresses {base,8'h00}+wptr+0, +4, +8 and +12. The beats carry these dwords:
  - dword 0 is {24'b0, source id};
  - dword 1 is {4'b0, 28-bit source data};
  - dword 2 is {16-bit address-space id, 8-bit vm id, 8-bit ring id};
  - dword 3 is zero.
- R2: The write pointer is a byte offset. It advances by 16 after the last beat of a vector and wraps modulo the ring size in bytes, which is 4 << size field. The size field holds log2 of the ring size in dwords.
- R3: The registered interrupt output is high while the ring is enabled and either the read pointer differs from the write pointer or the overflow flag is set. Otherwise it is low.
- R4: When overflow detection is on and a completed vector moves the write pointer onto the read pointer, bit 0 of the write-pointer word is set and stays set. Writing continues and wraps over the oldest entry. With detection off, the bit stays 0.
- R5: Writing 1 to control bit 10 clears the overflow flag. Bit 10 is not stored and always reads back 0.
- R6: When writeback is on, each vector is followed by one extra beat to address {wb_high[7:0], wb_low}. That beat carries the updated write-pointer word, including the flag. When writeback is off, no extra beat is sent.
- R7: Events are accepted only while both control bit 0 (ring enable) and control bit 1 (interrupt enable) are 1. Clearing either bit does all of the following:
  - resets the read pointer, the write pointer and the overflow flag to 0;
  - discards queued events;
  - drops the interrupt output.
- R8: When control bit 4 (re-arm) is set, a write to the read pointer forces the interrupt output low for exactly one cycle. After that cycle the output follows R3 again. When re-arm is clear, a read-pointer write does not make the output dip.
- R9: Events are buffered in a 4-entry FIFO. While the memory port stalls with nothing in flight, exactly 5 events are accepted and then the event ready signal goes low. Busy is high while anything is queued or in flight. A memory request holds its address and data until it is accepted.
- R10: The register words are selected by reg_addr:
  - 0: control, with bit 0 ring enable, bit 1 interrupt enable, bit 2 overflow detection, bit 3 writeback, bit 4 re-arm, bits 9:5 size and bit 10 overflow clear;
  - 1: ring base, address bits 39:8;
  - 2: read pointer;
  - 3: write-pointer word, read-only;
  - 4: writeback low;
  - 5: writeback high.
  
  Read-pointer writes are masked to the ring size and to 16-byte alignment.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | Event offered |
| ev_src_id | input | 8 | Event source identifier |
| ev_src_data | input | 28 | Event source data |
| ev_ring_id | input | 8 | Event ring identifier |
| ev_vmid | input | 8 | Event virtual-memory identifier |
| ev_pasid | input | 16 | Event address-space identifier |
| ev_ready | output | 1 | Event accepted on this edge if valid |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_valid | output | 1 | Memory write request valid |
| mem_addr | output | 40 | Memory byte address |
| mem_data | output | 32 | Memory write data |
| mem_ready | input | 1 | Memory accepts the request |
| irq | output | 1 | Ring holds unread data or has overflowed |
| busy | output | 1 | Events queued or write in flight |

## Verification
The bench drives the ring all the way around until the write pointer lands exactly on the read pointer. A design that tests for overflow when a vector starts instead of when it completes, or that stops writing after an overflow, would report the wrong pointer word or lose the vector that overwrites the oldest slot.

It times the one-cycle interrupt dip in re-arm mode against a read-pointer write in plain mode. A design that ignored the mode, or that held the dip too long, would show the wrong level on one of the two sampled cycles.

It stalls the memory port to find the FIFO capacity. A FIFO that is one entry too deep or too shallow changes how many events are accepted.

It toggles the enable bits to confirm that the pointers are cleared. Long random runs with memory stalls then check the beat order, the address arithmetic and the writeback word against a bench model.

// File: rtl/ivr_pkg.sv
package ivr_pkg;

  localparam int unsigned ADDR_W    = 40;
  localparam int unsigned VEC_BYTES = 16;

  localparam logic [2:0] RA_CTRL = 3'd0;
  localparam logic [2:0] RA_BASE = 3'd1;
  localparam logic [2:0] RA_RPTR = 3'd2;
  localparam logic [2:0] RA_WPTR = 3'd3;
  localparam logic [2:0] RA_WBLO = 3'd4;
  localparam logic [2:0] RA_WBHI = 3'd5;

  localparam int unsigned CB_RING_EN = 0;
  localparam int unsigned CB_INTR_EN = 1;
  localparam int unsigned CB_OVF_DET = 2;
  localparam int unsigned CB_WB_EN   = 3;
  localparam int unsigned CB_REARM   = 4;
  localparam int unsigned CB_SIZE_LO = 5;
  localparam int unsigned CB_SIZE_HI = 9;
  localparam int unsigned CB_OVF_CLR = 10;

  typedef struct packed {
    logic [7:0]  src_id;
    logic [27:0] src_data;
    logic [7:0]  ring_id;
    logic [7:0]  vmid;
    logic [15:0] pasid;
  } ivr_event_t;

  typedef enum logic [1:0] {
    ENG_IDLE = 2'd0,
    ENG_DATA = 2'd1,
    ENG_WB   = 2'd2
  } eng_state_t;

endpackage

// File: rtl/ivr_evt_fifo.sv
module ivr_evt_fifo #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);

  localparam int unsigned IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [IW-1:0] rd_q, rd_d, wr_q, wr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign dout    = mem_q[rd_q];

  always_comb begin
    rd_d  = rd_q;
    wr_d  = wr_q;
    cnt_d = cnt_q;
    if (flush) begin
      rd_d  = '0;
      wr_d  = '0;
      cnt_d = '0;
    end else begin
      if (do_push) wr_d = (wr_q == IW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_d = (rd_q == IW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      if (do_push && !do_pop)      cnt_d = cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem_q[wr_q] <= din;
  end

  // R9
  fifo_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

endmodule

// File: rtl/ivr_regs.sv
module ivr_regs
  import ivr_pkg::*;
#(
  parameter int unsigned PTR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [PTR_W-1:0]  wptr_word,
  output logic              enabled,
  output logic              ovf_det,
  output logic              wb_en,
  output logic              rearm,
  output logic              ovf_clr,
  output logic              rptr_wr,
  output logic [PTR_W-1:0]  mask,
  output logic [PTR_W-1:0]  rptr,
  output logic [31:0]       base,
  output logic [ADDR_W-1:0] wb_addr
);

  localparam logic [PTR_W-1:0] ALIGN_M = ~PTR_W'(VEC_BYTES - 1);

  logic [CB_SIZE_HI:0] ctrl_q, ctrl_d;
  logic [31:0]         base_q, base_d, wblo_q, wblo_d;
  logic [7:0]          wbhi_q, wbhi_d;
  logic [PTR_W-1:0]    rptr_q, rptr_d;
  logic [4:0]          size_f;
  logic                hit_ctrl, hit_base, hit_rptr, hit_wblo, hit_wbhi;

  assign hit_ctrl = reg_we && (reg_addr == RA_CTRL);
  assign hit_base = reg_we && (reg_addr == RA_BASE);
  assign hit_rptr = reg_we && (reg_addr == RA_RPTR);
  assign hit_wblo = reg_we && (reg_addr == RA_WBLO);
  assign hit_wbhi = reg_we && (reg_addr == RA_WBHI);

  assign enabled = ctrl_q[CB_RING_EN] && ctrl_q[CB_INTR_EN];
  assign ovf_det = ctrl_q[CB_OVF_DET];
  assign wb_en   = ctrl_q[CB_WB_EN];
  assign rearm   = ctrl_q[CB_REARM];
  assign size_f  = ctrl_q[CB_SIZE_HI:CB_SIZE_LO];
  assign ovf_clr = hit_ctrl && reg_wdata[CB_OVF_CLR];
  assign rptr_wr = hit_rptr && enabled;
  assign rptr    = rptr_q;
  assign base    = base_q;
  assign wb_addr = {wbhi_q, wblo_q};

  always_comb begin
    for (int i = 0; i < int'(PTR_W); i++) begin
      mask[i] = (i < 4) || (i < int'(size_f) + 2);
    end
  end

  always_comb begin
    ctrl_d = hit_ctrl ? reg_wdata[CB_SIZE_HI:0] : ctrl_q;
    base_d = hit_base ? reg_wdata : base_q;
    wblo_d = hit_wblo ? reg_wdata : wblo_q;
    wbhi_d = hit_wbhi ? reg_wdata[7:0] : wbhi_q;
    if (!enabled)      rptr_d = '0;
    else if (hit_rptr) rptr_d = reg_wdata[PTR_W-1:0] & mask & ALIGN_M;
    else               rptr_d = rptr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      base_q <= '0;
      wblo_q <= '0;
      wbhi_q <= '0;
      rptr_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      base_q <= base_d;
      wblo_q <= wblo_d;
      wbhi_q <= wbhi_d;
      rptr_q <= rptr_d;
    end
  end

  always_comb begin
    case (reg_addr)
      RA_CTRL: reg_rdata = 32'(ctrl_q);
      RA_BASE: reg_rdata = base_q;
      RA_RPTR: reg_rdata = 32'(rptr_q);
      RA_WPTR: reg_rdata = 32'(wptr_word);
      RA_WBLO: reg_rdata = wblo_q;
      RA_WBHI: reg_rdata = {24'b0, wbhi_q};
      default: reg_rdata = '0;
    endcase
  end

  // R7
  dis_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enabled |=> (rptr_q == '0));

endmodule

// File: rtl/ivr_wr_engine.sv
module ivr_wr_engine
  import ivr_pkg::*;
#(
  parameter int unsigned PTR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enabled,
  input  logic              ovf_det,
  input  logic              wb_en,
  input  logic              ovf_clr,
  input  logic [PTR_W-1:0]  mask,
  input  logic [PTR_W-1:0]  rptr,
  input  logic [31:0]       base,
  input  logic [ADDR_W-1:0] wb_addr,
  input  logic              fifo_empty,
  input  ivr_event_t        ev_in,
  output logic              pop,
  output logic              mem_valid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_data,
  input  logic              mem_ready,
  output logic [PTR_W-1:0]  wptr,
  output logic              ovf,
  output logic              idle
);

  localparam logic [PTR_W-1:0] STEP = PTR_W'(VEC_BYTES);

  eng_state_t       state_q, state_d;
  logic [1:0]       beat_q, beat_d;
  ivr_event_t       ev_q, ev_d;
  logic [PTR_W-1:0] wptr_q, wptr_d, nxt_wptr;
  logic             ovf_q, ovf_d, ovf_set, last_done;
  logic [31:0]      vec_dw;
  logic [ADDR_W-1:0] ring_addr;

  assign last_done = (state_q == ENG_DATA) && mem_ready && (beat_q == 2'd3);
  assign nxt_wptr  = (wptr_q + STEP) & mask;
  assign ovf_set   = last_done && ovf_det && (nxt_wptr == rptr);

  always_comb begin
    state_d = state_q;
    beat_d  = beat_q;
    ev_d    = ev_q;
    pop     = 1'b0;
    case (state_q)
      ENG_IDLE: begin
        if (enabled && !fifo_empty) begin
          pop     = 1'b1;
          ev_d    = ev_in;
          beat_d  = 2'd0;
          state_d = ENG_DATA;
        end
      end
      ENG_DATA: begin
        if (mem_ready) begin
          if (beat_q == 2'd3) state_d = wb_en ? ENG_WB : ENG_IDLE;
          else                beat_d  = beat_q + 2'd1;
        end
      end
      ENG_WB: begin
        if (mem_ready) state_d = ENG_IDLE;
      end
      default: state_d = ENG_IDLE;
    endcase
  end

  always_comb begin
    wptr_d = last_done ? nxt_wptr : wptr_q;
    ovf_d  = (ovf_q && !ovf_clr) || ovf_set;
    if (!enabled) begin
      wptr_d = '0;
      ovf_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ENG_IDLE;
      beat_q  <= '0;
      wptr_q  <= '0;
      ovf_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      beat_q  <= beat_d;
      wptr_q  <= wptr_d;
      ovf_q   <= ovf_d;
    end
  end

  always_ff @(posedge clk) begin
    if (pop) ev_q <= ev_d;
  end

  always_comb begin
    case (beat_q)
      2'd0:    vec_dw = {24'b0, ev_q.src_id};
      2'd1:    vec_dw = {4'b0, ev_q.src_data};
      2'd2:    vec_dw = {ev_q.pasid, ev_q.vmid, ev_q.ring_id};
      default: vec_dw = '0;
    endcase
  end

  assign ring_addr = {base, 8'h00} + ADDR_W'(wptr_q) + ADDR_W'({beat_q, 2'b00});

  assign mem_valid = (state_q != ENG_IDLE);
  assign mem_addr  = (state_q == ENG_WB) ? wb_addr : ring_addr;
  assign mem_data  = (state_q == ENG_WB) ? 32'({wptr_q[PTR_W-1:1], ovf_q}) : vec_dw;
  assign wptr      = wptr_q;
  assign ovf       = ovf_q;
  assign idle      = (state_q == ENG_IDLE);

  // R9
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data)));

  // R2
  wptr_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wptr_q) |-> ($past(last_done) || !$past(enabled)));

  // R5
  ovf_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovf_q) |-> ($past(ovf_clr) || !$past(enabled)));

endmodule

// File: rtl/ivr_ring_writer.sv
module ivr_ring_writer
  import ivr_pkg::*;
#(
  parameter int unsigned PTR_W      = 20,
  parameter int unsigned FIFO_DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ev_valid,
  input  logic [7:0]  ev_src_id,
  input  logic [27:0] ev_src_data,
  input  logic [7:0]  ev_ring_id,
  input  logic [7:0]  ev_vmid,
  input  logic [15:0] ev_pasid,
  output logic        ev_ready,
  input  logic        reg_we,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_valid,
  output logic [39:0] mem_addr,
  output logic [31:0] mem_data,
  input  logic        mem_ready,
  output logic        irq,
  output logic        busy
);

  localparam int unsigned EV_W = $bits(ivr_event_t);

  ivr_event_t        ev_pk, ev_head;
  logic [EV_W-1:0]   head_bits;
  logic              enabled, ovf_det, wb_en, rearm, ovf_clr, rptr_wr;
  logic [PTR_W-1:0]  mask, rptr, wptr;
  logic [31:0]       base;
  logic [ADDR_W-1:0] wb_addr;
  logic              fifo_empty, fifo_full, pop, ovf, eng_idle, push;
  logic              irq_q, irq_d;

  assign ev_pk    = '{src_id: ev_src_id, src_data: ev_src_data, ring_id: ev_ring_id,
                      vmid: ev_vmid, pasid: ev_pasid};
  assign ev_ready = enabled && !fifo_full;
  assign push     = ev_valid && ev_ready;
  assign ev_head  = ivr_event_t'(head_bits);

  ivr_regs #(.PTR_W(PTR_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .wptr_word({wptr[PTR_W-1:1], ovf}),
    .enabled(enabled), .ovf_det(ovf_det), .wb_en(wb_en), .rearm(rearm),
    .ovf_clr(ovf_clr), .rptr_wr(rptr_wr), .mask(mask), .rptr(rptr),
    .base(base), .wb_addr(wb_addr)
  );

  ivr_evt_fifo #(.DEPTH(FIFO_DEPTH), .W(EV_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(!enabled),
    .push(push), .din(ev_pk), .pop(pop), .dout(head_bits),
    .empty(fifo_empty), .full(fifo_full)
  );

  ivr_wr_engine #(.PTR_W(PTR_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .enabled(enabled), .ovf_det(ovf_det), .wb_en(wb_en),
    .ovf_clr(ovf_clr), .mask(mask), .rptr(rptr), .base(base), .wb_addr(wb_addr),
    .fifo_empty(fifo_empty), .ev_in(ev_head), .pop(pop),
    .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_data(mem_data), .mem_ready(mem_ready),
    .wptr(wptr), .ovf(ovf), .idle(eng_idle)
  );

  always_comb begin
    irq_d = enabled && ((rptr != wptr) || ovf) && !(rearm && rptr_wr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq  = irq_q;
  assign busy = !fifo_empty || !eng_idle;

  // R3
  irq_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> $past(enabled));

  // R8
  rearm_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rearm && rptr_wr) |=> !irq_q);

endmodule

// File: tb/sim_ivr_ring_writer.sv
module sim_ivr_ring_writer;

  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 100000;

  logic        clk, rst_n;
  logic        ev_valid, ev_ready;
  logic [7:0]  ev_src_id, ev_ring_id, ev_vmid;
  logic [27:0] ev_src_data;
  logic [15:0] ev_pasid;
  logic        reg_we;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        mem_valid, mem_ready;
  logic [39:0] mem_addr;
  logic [31:0] mem_data;
  logic        irq, busy;

  int n_chk = 0;
  int n_fail = 0;
  int rdy_mode = 1;

  logic [39:0] ga[$], ea[$];
  logic [31:0] gd[$], ed[$];

  logic [31:0] m_base, m_wptr, m_rptr;
  logic [39:0] m_wb;
  int          m_sz;
  bit          m_wb_en, m_ovf_en, m_ovf;

  ivr_ring_writer u0 (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_src_id(ev_src_id),
    .ev_src_data(ev_src_data), .ev_ring_id(ev_ring_id), .ev_vmid(ev_vmid),
    .ev_pasid(ev_pasid), .ev_ready(ev_ready), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_valid(mem_valid),
    .mem_addr(mem_addr), .mem_data(mem_data), .mem_ready(mem_ready),
    .irq(irq), .busy(busy)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk)
    mem_ready = (rdy_mode == 1) || ((rdy_mode == 2) && ($urandom % 4 != 0));

  always @(posedge clk)
    if (rst_n && mem_valid && mem_ready) begin
      ga.push_back(mem_addr);
      gd.push_back(mem_data);
    end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] f_mask(input int sz);
    int s;
    s = (sz < 2) ? 2 : sz;
    return (32'd4 << s) - 32'd1;
  endfunction

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic set_ctrl(input bit en, input bit ie, input bit od, input bit wb,
                          input bit ra, input int sz, input bit clr);
    logic [4:0] s5;
    s5 = sz[4:0];
    wr_reg(3'd0, {21'b0, clr, s5, ra, wb, od, ie, en});
    m_sz = sz; m_ovf_en = od; m_wb_en = wb;
    if (clr) m_ovf = 1'b0;
    if (!(en && ie)) begin m_wptr = 0; m_rptr = 0; m_ovf = 1'b0; end
  endtask

  task automatic predict(input logic [7:0] sid, input logic [27:0] sd, input logic [7:0] rid,
                         input logic [7:0] vm, input logic [15:0] pa);
    logic [39:0] a0;
    logic [31:0] nxt;
    a0 = {m_base, 8'h00} + 40'(m_wptr);
    ea.push_back(a0);        ed.push_back({24'b0, sid});
    ea.push_back(a0 + 40'd4);  ed.push_back({4'b0, sd});
    ea.push_back(a0 + 40'd8);  ed.push_back({pa, vm, rid});
    ea.push_back(a0 + 40'd12); ed.push_back(32'd0);
    nxt = (m_wptr + 32'd16) & f_mask(m_sz);
    if (m_ovf_en && (nxt == m_rptr)) m_ovf = 1'b1;
    m_wptr = nxt;
    if (m_wb_en) begin
      ea.push_back(m_wb);
      ed.push_back(m_wptr | 32'(m_ovf));
    end
  endtask

  task automatic send(input logic [7:0] sid, input logic [27:0] sd, input logic [7:0] rid,
                      input logic [7:0] vm, input logic [15:0] pa);
    @(negedge clk);
    ev_src_id = sid; ev_src_data = sd; ev_ring_id = rid; ev_vmid = vm; ev_pasid = pa;
    ev_valid = 1'b1;
    while (!ev_ready) @(negedge clk);
    predict(sid, sd, rid, vm, pa);
    @(posedge clk);
    @(negedge clk);
    ev_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic check_beats(input string req);
    int n;
    wait_idle();
    chk({req, " beat count"}, 64'(ga.size()), 64'(ea.size()));
    n = (ga.size() < ea.size()) ? ga.size() : ea.size();
    for (int i = 0; i < n; i++) begin
      chk({req, " beat addr"}, 64'(ga[i]), 64'(ea[i]));
      chk({req, " beat data"}, 64'(gd[i]), 64'(ed[i]));
    end
    ga.delete(); gd.delete(); ea.delete(); ed.delete();
  endtask

  task automatic run_all();
    logic [31:0] r;
    int acc;
    // reset state: R7 R3 R10
    rd_reg(3'd3, r); chk("R2 reset wptr", 64'(r), 64'd0);
    rd_reg(3'd2, r); chk("R10 reset rptr", 64'(r), 64'd0);
    rd_reg(3'd0, r); chk("R10 reset ctrl", 64'(r), 64'd0);
    chk("R3 reset irq", 64'(irq), 64'd0);
    chk("R9 reset busy", 64'(busy), 64'd0);
    chk("R7 reset ev_ready", 64'(ev_ready), 64'd0);

    // basic vector with writeback: R1 R2 R6 R3
    m_base = 32'h000A_5C3; m_wb = {8'h12, 32'h0000_F000};
    wr_reg(3'd1, m_base); wr_reg(3'd4, 32'h0000_F000); wr_reg(3'd5, 32'h0000_0012);
    rd_reg(3'd5, r); chk("R10 wb high readback", 64'(r), 64'h12);
    set_ctrl(1, 1, 1, 1, 0, 4, 0);
    send(8'hA7, 28'hBCD_EF12, 8'h3C, 8'h5A, 16'hBEEF);
    check_beats("R1 R6 first vector");
    rd_reg(3'd3, r); chk("R2 wptr after one", 64'(r), 64'd16);
    chk("R3 irq unread", 64'(irq), 64'd1);

    // rearm: R8
    set_ctrl(1, 1, 1, 1, 1, 4, 0);
    send(8'h01, 28'h000_0002, 8'h03, 8'h04, 16'h0005);
    check_beats("R1 second vector");
    wr_reg(3'd2, 32'd16); m_rptr = 16;
    chk("R8 rearm dip", 64'(irq), 64'd0);
    @(negedge clk); chk("R8 rearm reassert", 64'(irq), 64'd1);
    set_ctrl(1, 1, 1, 1, 0, 4, 0);
    wr_reg(3'd2, 32'd16);
    chk("R8 no dip without rearm", 64'(irq), 64'd1);
    @(negedge clk); chk("R8 stays high", 64'(irq), 64'd1);
    wr_reg(3'd2, 32'd32); m_rptr = 32;
    @(negedge clk); chk("R3 irq low when caught up", 64'(irq), 64'd0);

    // overflow: R4 R5 R3
    for (int k = 0; k < 4; k++) send(8'(k), 28'(k * 3), 8'h10, 8'h20, 16'(k));
    check_beats("R4 wrap to overflow");
    rd_reg(3'd3, r); chk("R4 overflow flag set", 64'(r), 64'h21);
    chk("R3 irq on overflow", 64'(irq), 64'd1);
    send(8'hEE, 28'h123_4567, 8'h11, 8'h22, 16'h3333);
    check_beats("R4 overwrite oldest");
    rd_reg(3'd3, r); chk("R4 flag sticky", 64'(r), 64'h31);
    set_ctrl(1, 1, 1, 1, 0, 4, 1);
    rd_reg(3'd3, r); chk("R5 flag cleared", 64'(r), 64'h30);
    rd_reg(3'd0, r); chk("R5 clear bit reads 0", 64'(r), 64'h8F);

    // detection off: R4
    set_ctrl(1, 1, 0, 1, 0, 4, 0);
    for (int k = 0; k < 3; k++) send(8'h40, 28'h55, 8'h66, 8'h77, 16'h8888);
    check_beats("R4 detect off");
    rd_reg(3'd3, r); chk("R4 no flag when off", 64'(r), 64'd32);
    chk("R3 irq low equal ptrs", 64'(irq), 64'd0);

    // disable: R7
    set_ctrl(0, 1, 0, 1, 0, 4, 0);
    rd_reg(3'd3, r); chk("R7 wptr cleared", 64'(r), 64'd0);
    rd_reg(3'd2, r); chk("R7 rptr cleared", 64'(r), 64'd0);
    chk("R7 irq low", 64'(irq), 64'd0);
    chk("R7 ready low ring off", 64'(ev_ready), 64'd0);
    set_ctrl(1, 0, 0, 1, 0, 4, 0);
    @(negedge clk); chk("R7 ready low intr off", 64'(ev_ready), 64'd0);

    // no writeback: R6
    set_ctrl(1, 1, 1, 0, 0, 4, 0);
    send(8'h9A, 28'hFFF_FFFF, 8'hFF, 8'h00, 16'hFFFF);
    check_beats("R6 no writeback beat");

    // backpressure: R9
    set_ctrl(1, 1, 0, 1, 0, 4, 0);
    rdy_mode = 0;
    acc = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      ev_src_id = 8'(k); ev_src_data = 28'(k + 100); ev_ring_id = 8'h0B;
      ev_vmid = 8'h0C; ev_pasid = 16'(k * 7);
      ev_valid = 1'b1;
      if (!ev_ready) begin ev_valid = 1'b0; break; end
      predict(ev_src_id, ev_src_data, ev_ring_id, ev_vmid, ev_pasid);
      acc++;
    end
    ev_valid = 1'b0;
    chk("R9 accepted while stalled", 64'(acc), 64'd5);
    chk("R9 busy while stalled", 64'(busy), 64'd1);
    chk("R9 request pending", 64'(mem_valid), 64'd1);
    rdy_mode = 1;
    check_beats("R9 drained");

    // random: R1 R2 R6
    set_ctrl(0, 0, 0, 0, 0, 8, 0);
    m_base = 32'h0077_1200; wr_reg(3'd1, m_base);
    set_ctrl(1, 1, 1, 1, 0, 8, 0);
    rdy_mode = 2;
    for (int k = 0; k < 48; k++) begin
      send(8'($urandom), 28'($urandom), 8'($urandom), 8'($urandom), 16'($urandom));
      if (k % 8 == 7) begin
        wait_idle();
        wr_reg(3'd2, m_wptr); m_rptr = m_wptr;
      end
    end
    check_beats("R1 R6 random");
    rd_reg(3'd3, r); chk("R2 random wptr", 64'(r), 64'(m_wptr | 32'(m_ovf)));
    rdy_mode = 1;
  endtask

  initial begin
    void'($urandom(32'h1BAD_5EED));
    rst_n = 1'b0; ev_valid = 1'b0; reg_we = 1'b0; reg_addr = 3'd0; reg_wdata = '0;
    ev_src_id = '0; ev_src_data = '0; ev_ring_id = '0; ev_vmid = '0; ev_pasid = '0;
    mem_ready = 1'b1;
    m_base = '0; m_wptr = '0; m_rptr = '0; m_wb = '0; m_sz = 0;
    m_wb_en = 0; m_ovf_en = 0; m_ovf = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    fork
      run_all();
      begin
        repeat (WD_CYCLES) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule